// File: doc/BRIEF.md
# T=0 Transmit Parity Retry Controller

This block decides what the transmit side of a character-oriented smart card link does when the card rejects a character by signalling a parity error (a NAK) during the guard time. For each NAK it either asks the transmit engine to send the same character again or stops transmission altogether. It keeps a count of the NAKs the current character has received. A programmable threshold sets how many rejections are tolerated. A threshold of zero means the block never stops transmission, however many errors occur.

When a character collects one NAK more than the threshold, the block raises a lock towards the FIFO and the transmitter and pulses an interrupt. Transmission then stays stopped. While it is stopped, firmware can read the FIFO level to find which character failed and flush the FIFO. Firmware then sets the check-disable bit to release the lock. Holding that bit at 1 also stops parity errors from being checked. Clearing it back to 0 turns checking on again. A card activation resets the count and the lock.

All pins are plain control strobes and levels. No data passes through the block, so there is no valid/ready handshake and no back-pressure. Each strobe lasts one clock and is acted on in the cycle it is high. All outputs are registered and change at the clock edge that samples the stimulus.

Top module: `t0_retry_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, lock_o, retry_o and perr_irq_o are 0.
- R2: With limit_i = 0, NAKs never assert lock_o, and each accepted NAK gives a one-cycle retry_o pulse after the sampling edge.
- R3: With limit_i = L > 0, the first L NAKs of one character each give a retry_o pulse. The NAK numbered L+1 sets lock_o and gives a single-cycle perr_irq_o pulse with no retry_o. retry_o and perr_irq_o are never high together.
- R4: char_done_i without a NAK in the same cycle clears the count, so the threshold applies per character. A NAK in the same cycle as char_done_i is still counted.
- R5: While lock_o is high and unlock_i is 0, the lock holds. NAKs are ignored during this time: they give no retry_o and no perr_irq_o.
- R6: unlock_i = 1 while locked clears lock_o at the next edge and restarts the count from zero.
- R7: While unlock_i = 1, NAKs are not checked: they give no retry_o, no lock and no count. After unlock_i returns to 0, checking resumes.
- R8: card_act_i clears the count and the lock. It takes priority over a NAK in the same cycle, which is then dropped.
- R9: The count saturates at 15 (a 4-bit counter for a 3-bit limit) and never wraps. After 18 NAKs at limit 0 with no char_done_i, the next NAK under limit 7 locks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_act_i | input | 1 | Card activation strobe; clears count and lock |
| nak_i | input | 1 | Strobe: card NAKed the current character |
| char_done_i | input | 1 | Strobe: current character finished |
| unlock_i | input | 1 | Check-disable / unlock level from firmware |
| limit_i | input | 3 | Tolerated NAKs per character; 0 = never stop |
| lock_o | output | 1 | Transmission locked |
| retry_o | output | 1 | One-cycle request to resend the same character |
| perr_irq_o | output | 1 | One-cycle parity error interrupt on lock entry |

## Verification
The bound checker watches several rules on every cycle. The interrupt appears only in the cycle the lock rises, and never together with a retry. The lock is never entered at limit zero. A lock with unlock low and no activation persists. Activation or the unlock bit clears the lock, and while the unlock bit is high no retry or interrupt follows. The exact NAK number that trips the lock can only be shown by the bench's scenarios, because it depends on the count history. So can the per-character clearing by char_done_i, the restart after unlock, and the saturation of the count. Each of these needs a sequence of strobes followed by a check of the outputs.

// File: rtl/t0r_pkg.sv
package t0r_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_LOCK = 1'b1
  } lock_state_e;
endpackage

// File: rtl/t0r_nak_counter.sv
module t0r_nak_counter #(
  parameter int LIMIT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               inc_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic               hit_o
);
  localparam int CNT_W = LIMIT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clr_i)
      cnt_q <= '0;
    else if (inc_i && (cnt_q != CNT_MAX))
      cnt_q <= cnt_q + 1'b1;
  end

  // The next NAK is number limit+1 once the count has reached the limit.
  assign hit_o = (limit_i != '0) && (cnt_q >= {1'b0, limit_i});
endmodule

// File: rtl/t0r_lock_fsm.sv
module t0r_lock_fsm
  import t0r_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic unlock_i,
  input  logic trip_i,
  output logic lock_o,
  output logic release_o,
  output logic irq_o
);
  lock_state_e state_q, state_d;
  logic        irq_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (!act_i && trip_i) state_d = ST_LOCK;
      ST_LOCK: if (act_i || unlock_i) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= (state_q == ST_RUN) && (state_d == ST_LOCK);
    end
  end

  assign lock_o    = (state_q == ST_LOCK);
  assign release_o = (state_q == ST_LOCK) && (state_d == ST_RUN);
  assign irq_o     = irq_q;
endmodule

// File: rtl/t0_retry_ctrl.sv
module t0_retry_ctrl #(
  parameter int LIMIT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               card_act_i,
  input  logic               nak_i,
  input  logic               char_done_i,
  input  logic               unlock_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic               lock_o,
  output logic               retry_o,
  output logic               perr_irq_o
);
  logic nak_live;
  logic hit;
  logic trip;
  logic rel;
  logic cnt_clr;
  logic cnt_inc;
  logic retry_q;

  // A NAK counts only while checking is enabled and the lock is open.
  assign nak_live = nak_i && !unlock_i && !lock_o;
  assign trip     = nak_live && hit && !card_act_i;
  assign cnt_inc  = nak_live && !card_act_i;
  assign cnt_clr  = card_act_i || rel || (char_done_i && !nak_live);

  t0r_nak_counter #(.LIMIT_W(LIMIT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (cnt_clr),
    .inc_i   (cnt_inc),
    .limit_i (limit_i),
    .hit_o   (hit)
  );

  t0r_lock_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_i     (card_act_i),
    .unlock_i  (unlock_i),
    .trip_i    (trip),
    .lock_o    (lock_o),
    .release_o (rel),
    .irq_o     (perr_irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      retry_q <= 1'b0;
    else
      retry_q <= nak_live && !hit && !card_act_i;
  end

  assign retry_o = retry_q;
endmodule

// File: rtl/t0_retry_chk.sv
module t0_retry_chk #(
  parameter int LIMIT_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               card_act_i,
  input logic               unlock_i,
  input logic [LIMIT_W-1:0] limit_i,
  input logic               lock_o,
  input logic               retry_o,
  input logic               perr_irq_o
);
  // R3
  irq_on_lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perr_irq_o |-> (lock_o && !$past(lock_o)));

  // R3
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perr_irq_o |=> !perr_irq_o);

  // R3
  retry_irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(retry_o && perr_irq_o));

  // R2
  no_lock_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_i == '0 && !lock_o) |=> !lock_o);

  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !unlock_i && !card_act_i) |=> (lock_o && !retry_o && !perr_irq_o));

  // R6
  unlock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && unlock_i) |=> !lock_o);

  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_i |=> (!retry_o && !perr_irq_o && !lock_o));

  // R8
  act_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_act_i |=> (!lock_o && !retry_o && !perr_irq_o));
endmodule

bind t0_retry_ctrl t0_retry_chk #(.LIMIT_W(LIMIT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .card_act_i (card_act_i),
  .unlock_i   (unlock_i),
  .limit_i    (limit_i),
  .lock_o     (lock_o),
  .retry_o    (retry_o),
  .perr_irq_o (perr_irq_o)
);

// File: tb/sim_t0_retry_ctrl.sv
module sim_t0_retry_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       card_act_i = 1'b0;
  logic       nak_i = 1'b0;
  logic       char_done_i = 1'b0;
  logic       unlock_i = 1'b0;
  logic [2:0] limit_i = 3'd0;
  logic       lock_o, retry_o, perr_irq_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  t0_retry_ctrl #(.LIMIT_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .card_act_i(card_act_i), .nak_i(nak_i),
    .char_done_i(char_done_i), .unlock_i(unlock_i), .limit_i(limit_i),
    .lock_o(lock_o), .retry_o(retry_o), .perr_irq_o(perr_irq_o)
  );

  // Vector: [13:10] requirement number, [9] act, [8] nak, [7] done,
  // [6] unlock, [5:3] limit, [2] exp lock, [1] exp retry, [0] exp irq.
  localparam int NV = 27;
  localparam logic [13:0] VEC [NV] = '{
    14'b0010_0100_000_010, // R2 limit 0 retries
    14'b0010_0100_000_010, // R2
    14'b0100_0010_010_000, // R4 done clears
    14'b0011_0100_010_010, // R3 NAK 1 of limit 2
    14'b0011_0100_010_010, // R3 NAK 2
    14'b0011_0100_010_101, // R3 NAK 3 locks, irq
    14'b0101_0000_010_100, // R5 irq single, lock held
    14'b0101_0100_010_100, // R5 NAK ignored while locked
    14'b0110_0001_010_000, // R6 unlock releases
    14'b0110_0000_010_000, // R6
    14'b0110_0100_010_010, // R6 count restarted
    14'b0100_0010_010_000, // R4 done clears
    14'b0100_0100_010_010, // R4 new character NAK 1
    14'b0100_0100_010_010, // R4 NAK 2
    14'b1000_1100_010_000, // R8 act beats NAK
    14'b1000_0100_010_010, // R8 count cleared
    14'b1000_0100_010_010, // R8
    14'b1000_0100_010_101, // R8 lock again
    14'b1000_1000_010_000, // R8 act releases lock
    14'b0111_0101_001_000, // R7 NAK unchecked
    14'b0111_0101_001_000, // R7
    14'b0111_0100_001_010, // R7 checking back, NAK 1 of limit 1
    14'b0111_0100_001_101, // R7 NAK 2 locks
    14'b0110_0001_001_000, // R6 release
    14'b0100_0110_001_010, // R4 NAK with done still counts
    14'b0100_0100_001_101, // R4 second NAK locks
    14'b0110_0001_001_000  // R6 release
  };

  task automatic check(input string req, input logic [2:0] exp);
    checks++;
    if ({lock_o, retry_o, perr_irq_o} !== exp) begin
      fails++;
      $display("FAIL %s lock/retry/irq got %b expected %b", req,
               {lock_o, retry_o, perr_irq_o}, exp);
    end
  endtask

  task automatic cyc(input logic a, input logic n, input logic d,
                     input logic u, input logic [2:0] l);
    card_act_i = a; nak_i = n; char_done_i = d; unlock_i = u; limit_i = l;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 3'b000);          // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 3'b000);          // R1 after release

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5:3]);
      check($sformatf("R%0d", VEC[i][13:10]), VEC[i][2:0]);
    end
    cyc(0, 0, 0, 0, 3'd0);

    // R9: saturation, 18 NAKs at limit 0 then limit 7
    for (int k = 0; k < 18; k++) begin
      cyc(0, 1, 0, 0, 3'd0);
      check("R9", 3'b010);
    end
    cyc(0, 1, 0, 0, 3'd7);
    check("R9", 3'b101);
    cyc(0, 0, 0, 1, 3'd7);
    check("R9", 3'b000);

    // R1: reset while locked
    cyc(0, 1, 0, 0, 3'd1);
    cyc(0, 1, 0, 0, 3'd1);
    check("R3", 3'b101);
    cyc(0, 0, 0, 0, 3'd1);
    rst_n = 1'b0;
    #1;
    check("R1", 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 3'b000);
    cyc(0, 1, 0, 0, 3'd1);
    check("R1", 3'b010);          // count cleared by reset

    finish_run();
  end
endmodule